// File: doc/BRIEF.md
# Receive Destination Address Filter

This block screens the 48-bit destination address of each incoming frame and decides whether the frame is kept. It also reports whether a kept frame was taken as multicast or broadcast. Three receive-mode bits are checked first, in a fixed priority. If none of them applies, the address must exactly equal one of 16 stored table addresses whose enable bit is set. The decision, the type flags and a registered vector of matching entries appear one clock after the address strobe.

The table is filled by a load sequencer. The sequencer walks a descriptor list in memory through a one-outstanding word-read port. Each descriptor names its own table slot and carries three address words. A final word after the list becomes the enable mask. The sequencer is a state machine with these states:
- `LD_IDLE`: waits for a start pulse.
- `LD_IDX_REQ` and `LD_IDX_WAIT`: fetch the slot word.
- `LD_ADR_REQ` and `LD_ADR_WAIT`: fetch the three address words, looping once per word.
- `LD_ADVANCE`: writes the entry, counts down and steps the pointer.
- `LD_EN_REQ` and `LD_EN_WAIT`: fetch the enable word.
- `LD_FINISH`: signals completion.

The transitions are:
- start → `LD_IDX_REQ` when the count is non-zero, otherwise → `LD_EN_REQ`.
- Each `REQ` state → its `WAIT` state.
- `LD_IDX_WAIT` → `LD_ADR_REQ` on a response.
- `LD_ADR_WAIT` → `LD_ADR_REQ` until the third word has arrived, then → `LD_ADVANCE`.
- `LD_ADVANCE` → `LD_IDX_REQ` while entries remain, otherwise → `LD_EN_REQ`.
- `LD_EN_WAIT` → `LD_FINISH` on a response.
- `LD_FINISH` → `LD_IDLE`.

In reset mode, software can read the table back one word at a time.

Top module: `rx_dest_filter`

## Requirements
- R1: With `rx_mode` bit 12 set (promiscuous), an address whose first byte (`dst_addr[47:40]`) has bit 0 clear is accepted with no type flag. An address with that bit set is not accepted by this rule.
- R2: Otherwise, with `rx_mode` bit 11 set (all multicast), an address whose first byte has bit 0 set is accepted with `dec_mcast` high. This rule wins over R3 for the all-ones address.
- R3: Otherwise, with `rx_mode` bit 13 set (broadcast), the all-ones address is accepted with `dec_bcast` high. With bit 13 clear, the all-ones address falls through to the table check.
- R4: Otherwise, the address is accepted, with no flag, only if it equals an entry whose `en_mask` bit is set. Table word 1 forms bits 47:32, word 2 bits 31:16 and word 3 bits 15:0. A match to a disabled entry, or no match, rejects the frame.
- R5: `dec_valid` is high for exactly one cycle, one clock after each `dst_valid` cycle, and never otherwise.
- R6: A load runs once per descriptor while the low 5 bits of the count are non-zero. Each descriptor is four words. The low 4 bits of word 0 select the slot, and the upper bits are ignored. With a zero low count, only the enable word is read.
- R7: Word k of a descriptor is read at byte address ptr + k·2 when `bus_wide`=0, or ptr + k·4 when `bus_wide`=1. The pointer advances by four words per descriptor.
- R8: The word read at the pointer after the last descriptor becomes `en_mask`. `en_mask` changes at no other time.
- R9: At completion, `load_done` pulses for one cycle and `load_busy` falls. `lcd_flag` (status bit 0x1000) then stays set until `lcd_clr`.
- R10: With `reset_mode` high, `rb_data` returns word `rb_sel` (0 = bits 47:32, 1 = bits 31:16, 2 = bits 15:0) of entry `rb_ptr`. With `reset_mode` low, or with `rb_sel`=3, it returns zero.
- R11: Each read request lasts one cycle and is followed by a wait for its response, so at most one read is outstanding.
- R12: A `load_start` pulse while a load is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1: 4-byte word step, 0: 2-byte step |
| reset_mode | input | 1 | Enables table readback |
| rx_mode | input | 16 | Receive mode bits (12 promiscuous, 11 all multicast, 13 broadcast) |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first byte in bits 47:40 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_mcast | output | 1 | Accepted as multicast |
| dec_bcast | output | 1 | Accepted as broadcast |
| dec_hits | output | 16 | Registered per-entry match vector |
| load_start | input | 1 | Start table load |
| load_base | input | 32 | Descriptor list byte address |
| load_count | input | 16 | Descriptor count (low 5 bits used) |
| load_busy | output | 1 | Load command in progress |
| load_done | output | 1 | Load completion pulse |
| lcd_flag | output | 1 | Sticky load-complete status |
| lcd_clr | input | 1 | Clears `lcd_flag` |
| en_mask | output | 16 | Entry enable mask |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word read byte address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 16 | Read response data |
| rb_ptr | input | 4 | Readback entry pointer |
| rb_sel | input | 2 | Readback word select |
| rb_data | output | 16 | Readback data |

## Verification
The hardest situation to reach is a second start pulse arriving in the middle of a multi-word fetch. That pulse must change neither the address sequence nor the final table. The stimulus fires it while a response is still pending. Every memory address is checked against a queue the load task filled when it built the descriptors. The priority between promiscuous, multicast, broadcast and table rules also needs crafted addresses. A multicast address is stored in the table and a disabled entry matches exactly, so each rule's boundary is exposed at the decision port.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned ENTRIES    = 16;
    localparam int unsigned ADDR_BITS  = 48;
    localparam int unsigned WORD_BITS  = 16;
    localparam int unsigned MEM_ABITS  = 32;
    localparam int unsigned COUNT_BITS = 5;
    localparam int unsigned MODE_BITS  = 16;
    localparam int unsigned MB_PROMISC = 12;
    localparam int unsigned MB_ALLMC   = 11;
    localparam int unsigned MB_BCAST   = 13;

    typedef enum logic [3:0] {
        LD_IDLE,
        LD_IDX_REQ,
        LD_IDX_WAIT,
        LD_ADR_REQ,
        LD_ADR_WAIT,
        LD_ADVANCE,
        LD_EN_REQ,
        LD_EN_WAIT,
        LD_FINISH
    } ld_state_t;
endpackage

// File: rtl/rxf_cam.sv
module rxf_cam #(
    parameter int unsigned N  = rxf_pkg::ENTRIES,
    parameter int unsigned AW = rxf_pkg::ADDR_BITS,
    parameter int unsigned WW = rxf_pkg::WORD_BITS,
    localparam int unsigned IW  = $clog2(N),
    localparam int unsigned WPE = AW / WW,
    localparam int unsigned SW  = $clog2(WPE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic          en_wr,
    input  logic [N-1:0]  en_data,
    output logic [N-1:0]  en_mask,
    input  logic [AW-1:0] cmp_addr,
    output logic [N-1:0]  hit_vec,
    input  logic          rb_allow,
    input  logic [IW-1:0] rb_idx,
    input  logic [SW-1:0] rb_sel,
    output logic [WW-1:0] rb_data
);
    logic [AW-1:0] tbl_q [N];
    logic [N-1:0]  en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N); i++) tbl_q[i] <= '0;
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (en_wr)  en_q <= en_data;
    end

    assign en_mask = en_q;

    for (genvar g = 0; g < int'(N); g++) begin : g_cmp
        assign hit_vec[g] = en_q[g] && (tbl_q[g] == cmp_addr);
    end

    always_comb begin
        rb_data = '0;
        if (rb_allow && (int'(rb_sel) < int'(WPE)))
            rb_data = tbl_q[rb_idx][AW - 1 - int'(rb_sel) * int'(WW) -: WW];
    end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
    parameter int unsigned N  = rxf_pkg::ENTRIES,
    parameter int unsigned AW = rxf_pkg::ADDR_BITS,
    parameter int unsigned MW = rxf_pkg::MODE_BITS,
    parameter int unsigned BP = rxf_pkg::MB_PROMISC,
    parameter int unsigned BM = rxf_pkg::MB_ALLMC,
    parameter int unsigned BB = rxf_pkg::MB_BCAST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dst_valid,
    input  logic [AW-1:0] dst_addr,
    input  logic [MW-1:0] rx_mode,
    input  logic [N-1:0]  hit_vec,
    output logic          dec_valid,
    output logic          dec_accept,
    output logic          dec_mcast,
    output logic          dec_bcast,
    output logic [N-1:0]  dec_hits
);
    logic is_group, is_all_ones, acc_d, mc_d, bc_d;

    assign is_group    = dst_addr[AW-8];
    assign is_all_ones = &dst_addr;

    always_comb begin
        acc_d = 1'b0;
        mc_d  = 1'b0;
        bc_d  = 1'b0;
        if (rx_mode[BP] && !is_group) begin
            acc_d = 1'b1;
        end else if (rx_mode[BM] && is_group) begin
            acc_d = 1'b1;
            mc_d  = 1'b1;
        end else if (rx_mode[BB] && is_all_ones) begin
            acc_d = 1'b1;
            bc_d  = 1'b1;
        end else begin
            acc_d = |hit_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_mcast  <= 1'b0;
            dec_bcast  <= 1'b0;
            dec_hits   <= '0;
        end else begin
            dec_valid <= dst_valid;
            if (dst_valid) begin
                dec_accept <= acc_d;
                dec_mcast  <= mc_d;
                dec_bcast  <= bc_d;
                dec_hits   <= hit_vec;
            end
        end
    end

    p_one_cycle_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(dst_valid));
    p_flag_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_mcast || dec_bcast)) |-> dec_accept);
    p_single_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_mcast && dec_bcast));
endmodule

// File: rtl/rxf_loader.sv
module rxf_loader #(
    parameter int unsigned N   = rxf_pkg::ENTRIES,
    parameter int unsigned EW  = rxf_pkg::ADDR_BITS,
    parameter int unsigned WW  = rxf_pkg::WORD_BITS,
    parameter int unsigned MAW = rxf_pkg::MEM_ABITS,
    parameter int unsigned CW  = rxf_pkg::COUNT_BITS,
    localparam int unsigned IW  = $clog2(N),
    localparam int unsigned WPE = EW / WW,
    localparam int unsigned XW  = $clog2(WPE + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [MAW-1:0] base,
    input  logic [WW-1:0]  count_in,
    input  logic           wide,
    output logic           mem_req,
    output logic [MAW-1:0] mem_addr,
    input  logic           mem_rvalid,
    input  logic [WW-1:0]  mem_rdata,
    output logic           wr_en,
    output logic [IW-1:0]  wr_idx,
    output logic [EW-1:0]  wr_addr,
    output logic           en_wr,
    output logic [N-1:0]   en_data,
    output logic           busy,
    output logic           done
);
    import rxf_pkg::*;

    ld_state_t      state_q, state_d;
    logic [MAW-1:0] ptr_q;
    logic [CW-1:0]  cnt_q;
    logic [XW-1:0]  widx_q;
    logic [IW-1:0]  idx_q;
    logic [EW-1:0]  stage_q;
    logic           wide_q;
    logic [MAW-1:0] step, word_off;

    assign step = wide_q ? MAW'(4) : MAW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:     if (start) state_d = (count_in[CW-1:0] != '0) ? LD_IDX_REQ : LD_EN_REQ;
            LD_IDX_REQ:  state_d = LD_IDX_WAIT;
            LD_IDX_WAIT: if (mem_rvalid) state_d = LD_ADR_REQ;
            LD_ADR_REQ:  state_d = LD_ADR_WAIT;
            LD_ADR_WAIT: if (mem_rvalid)
                             state_d = (int'(widx_q) == int'(WPE)) ? LD_ADVANCE : LD_ADR_REQ;
            LD_ADVANCE:  state_d = (cnt_q != CW'(1)) ? LD_IDX_REQ : LD_EN_REQ;
            LD_EN_REQ:   state_d = LD_EN_WAIT;
            LD_EN_WAIT:  if (mem_rvalid) state_d = LD_FINISH;
            LD_FINISH:   state_d = LD_IDLE;
            default:     state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            cnt_q   <= '0;
            widx_q  <= '0;
            idx_q   <= '0;
            stage_q <= '0;
            wide_q  <= 1'b0;
        end else begin
            unique case (state_q)
                LD_IDLE: if (start) begin
                    ptr_q  <= base;
                    cnt_q  <= count_in[CW-1:0];
                    wide_q <= wide;
                end
                LD_IDX_WAIT: if (mem_rvalid) begin
                    idx_q  <= mem_rdata[IW-1:0];
                    widx_q <= XW'(1);
                end
                LD_ADR_WAIT: if (mem_rvalid) begin
                    stage_q <= {stage_q[EW-WW-1:0], mem_rdata};
                    widx_q  <= widx_q + XW'(1);
                end
                LD_ADVANCE: begin
                    cnt_q <= cnt_q - CW'(1);
                    ptr_q <= ptr_q + (step << 2);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        word_off = '0;
        mem_req  = 1'b0;
        wr_en    = 1'b0;
        en_wr    = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            LD_IDLE:     busy = 1'b0;
            LD_IDX_REQ:  mem_req = 1'b1;
            LD_ADR_REQ: begin
                mem_req  = 1'b1;
                word_off = MAW'(widx_q) * step;
            end
            LD_ADVANCE:  wr_en = 1'b1;
            LD_EN_REQ:   mem_req = 1'b1;
            LD_EN_WAIT:  en_wr = mem_rvalid;
            LD_FINISH: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr = ptr_q + word_off;
    assign wr_idx   = idx_q;
    assign wr_addr  = stage_q;
    assign en_data  = mem_rdata[N-1:0];

    p_req_then_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_done_drops_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_req) |=> $stable(ptr_q));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
    parameter int unsigned N   = rxf_pkg::ENTRIES,
    parameter int unsigned AW  = rxf_pkg::ADDR_BITS,
    parameter int unsigned WW  = rxf_pkg::WORD_BITS,
    parameter int unsigned MAW = rxf_pkg::MEM_ABITS,
    parameter int unsigned MW  = rxf_pkg::MODE_BITS,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned SW = $clog2(AW / WW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wide,
    input  logic           reset_mode,
    input  logic [MW-1:0]  rx_mode,
    input  logic           dst_valid,
    input  logic [AW-1:0]  dst_addr,
    output logic           dec_valid,
    output logic           dec_accept,
    output logic           dec_mcast,
    output logic           dec_bcast,
    output logic [N-1:0]   dec_hits,
    input  logic           load_start,
    input  logic [MAW-1:0] load_base,
    input  logic [WW-1:0]  load_count,
    output logic           load_busy,
    output logic           load_done,
    output logic           lcd_flag,
    input  logic           lcd_clr,
    output logic [N-1:0]   en_mask,
    output logic           mem_req,
    output logic [MAW-1:0] mem_addr,
    input  logic           mem_rvalid,
    input  logic [WW-1:0]  mem_rdata,
    input  logic [IW-1:0]  rb_ptr,
    input  logic [SW-1:0]  rb_sel,
    output logic [WW-1:0]  rb_data
);
    logic          wr_en, en_wr;
    logic [IW-1:0] wr_idx;
    logic [AW-1:0] wr_addr;
    logic [N-1:0]  en_data, hit_vec;

    rxf_loader #(.N(N), .EW(AW), .WW(WW), .MAW(MAW)) u_loader (
        .clk(clk), .rst_n(rst_n), .start(load_start), .base(load_base),
        .count_in(load_count), .wide(bus_wide), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .en_wr(en_wr),
        .en_data(en_data), .busy(load_busy), .done(load_done)
    );

    rxf_cam #(.N(N), .AW(AW), .WW(WW)) u_cam (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_addr(wr_addr), .en_wr(en_wr), .en_data(en_data),
        .en_mask(en_mask), .cmp_addr(dst_addr), .hit_vec(hit_vec),
        .rb_allow(reset_mode), .rb_idx(rb_ptr), .rb_sel(rb_sel),
        .rb_data(rb_data)
    );

    rxf_decide #(.N(N), .AW(AW), .MW(MW)) u_decide (
        .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
        .rx_mode(rx_mode), .hit_vec(hit_vec), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_mcast(dec_mcast),
        .dec_bcast(dec_bcast), .dec_hits(dec_hits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         lcd_flag <= 1'b0;
        else if (load_done) lcd_flag <= 1'b1;
        else if (lcd_clr)   lcd_flag <= 1'b0;
    end

    p_lcd_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_flag) |-> $past(load_done));
    p_mask_only_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_mask) |-> $past(load_busy));
endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wide = 1'b0, reset_mode = 1'b0;
    logic [15:0] rx_mode = '0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        dec_valid, dec_accept, dec_mcast, dec_bcast;
    logic [15:0] dec_hits;
    logic        load_start = 1'b0;
    logic [31:0] load_base = '0;
    logic [15:0] load_count = '0;
    logic        load_busy, load_done, lcd_flag;
    logic        lcd_clr = 1'b0;
    logic [15:0] en_mask;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  rb_ptr = '0;
    logic [1:0]  rb_sel = '0;
    logic [15:0] rb_data;

    always #2.5 clk = ~clk;

    rx_dest_filter dut_i (.*);

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] mem [0:1023];
    logic [47:0] tb_cam [16];
    logic [15:0] tb_en = '0;
    logic [2:0]  exp_q [$];
    logic [31:0] addr_q [$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: three-cycle read latency
    logic        r1 = 1'b0, r2 = 1'b0;
    logic [31:0] a1 = '0, a2 = '0;
    always @(posedge clk) begin
        r1 <= mem_req; a1 <= mem_addr;
        r2 <= r1;      a2 <= a1;
        mem_rvalid <= r2;
        mem_rdata  <= mem[a2[10:1]];
    end

    // address monitor (R7, R11)
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (addr_q.size() == 0) chk(1'b0, "R12 extra read", 64'(mem_addr), 64'(0));
            else begin
                logic [31:0] e;
                e = addr_q.pop_front();
                chk(mem_addr == e, "R7 read address", 64'(mem_addr), 64'(e));
            end
        end
    end

    // decision monitor (R1-R5)
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 spurious decision", 64'(1), 64'(0));
            else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                chk({dec_accept, dec_mcast, dec_bcast} == e, "R1 R2 R3 R4 decision",
                    64'({dec_accept, dec_mcast, dec_bcast}), 64'(e));
            end
        end
    end

    function automatic logic [2:0] predict(input logic [47:0] a, input logic [15:0] m);
        bit grp = a[40];
        if (m[12] && !grp) return 3'b100;
        if (m[11] && grp) return 3'b110;
        if (m[13] && (&a)) return 3'b101;
        for (int i = 0; i < 16; i++)
            if (tb_en[i] && tb_cam[i] == a) return 3'b100;
        return 3'b000;
    endfunction

    task automatic send(input logic [47:0] a);
        @(negedge clk);
        exp_q.push_back(predict(a, rx_mode));
        dst_addr = a; dst_valid = 1'b1;
        @(negedge clk);
        dst_valid = 1'b0;
        chk(dec_valid == 1'b1, "R5 valid after one clock", 64'(dec_valid), 64'(1));
        @(negedge clk);
        chk(dec_valid == 1'b0, "R5 single-cycle valid", 64'(dec_valid), 64'(0));
    endtask

    task automatic put_entry(input logic [31:0] b, input bit w, input int k,
                             input logic [15:0] w0, input logic [47:0] a);
        logic [31:0] st = w ? 32'd4 : 32'd2;
        logic [31:0] eb = b + 32'(k) * 4 * st;
        mem[eb[10:1]] = w0;
        mem[(eb + st) >> 1]     = a[47:32];
        mem[(eb + 2 * st) >> 1] = a[31:16];
        mem[(eb + 3 * st) >> 1] = a[15:0];
        for (int j = 0; j < 4; j++) addr_q.push_back(eb + 32'(j) * st);
        tb_cam[w0[3:0]] = a;
    endtask

    task automatic put_en(input logic [31:0] b, input bit w, input int n, input logic [15:0] e);
        logic [31:0] st = w ? 32'd4 : 32'd2;
        logic [31:0] ea = b + 32'(n) * 4 * st;
        mem[ea[10:1]] = e;
        addr_q.push_back(ea);
    endtask

    task automatic run_load(input logic [31:0] b, input bit w, input logic [15:0] cnt,
                            input logic [15:0] e, input bit poke);
        int t = 0;
        @(negedge clk);
        bus_wide = w; load_base = b; load_count = cnt; load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            load_base = 32'h380; load_count = 16'h0001; load_start = 1'b1; // R12
            @(negedge clk);
            load_start = 1'b0;
        end
        while (!load_done && t < 500) begin @(negedge clk); t++; end
        chk(load_done == 1'b1, "R9 done pulse", 64'(load_done), 64'(1));
        tb_en = e;
        @(negedge clk);
        chk(load_busy == 1'b0, "R9 busy cleared", 64'(load_busy), 64'(0));
        chk(load_done == 1'b0, "R9 done one cycle", 64'(load_done), 64'(0));
        chk(lcd_flag == 1'b1, "R9 status set", 64'(lcd_flag), 64'(1));
        chk(en_mask == e, "R8 enable word loaded", 64'(en_mask), 64'(e));
        chk(addr_q.size() == 0, "R6 all words read", 64'(addr_q.size()), 64'(0));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) tb_cam[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R5 reset valid", 64'(dec_valid), 64'(0));
        chk(load_busy == 1'b0 && lcd_flag == 1'b0, "R9 reset state", 64'({load_busy, lcd_flag}), 64'(0));
        chk(en_mask == 16'h0, "R8 reset mask", 64'(en_mask), 64'(0));

        // narrow load, three descriptors, upper slot bits are junk (R6), extra start mid-load (R12)
        put_entry(32'h040, 1'b0, 0, 16'hA5F3, 48'h0200_1122_3344);
        put_entry(32'h040, 1'b0, 1, 16'h0009, 48'h0300_5E00_0001);
        put_entry(32'h040, 1'b0, 2, 16'h7E0F, 48'h0A0B_0C0D_0E0F);
        put_en(32'h040, 1'b0, 3, 16'h0208);
        run_load(32'h040, 1'b0, 16'hFFE3, 16'h0208, 1'b1);

        @(negedge clk); lcd_clr = 1'b1;
        @(negedge clk); lcd_clr = 1'b0;
        chk(lcd_flag == 1'b0, "R9 status cleared", 64'(lcd_flag), 64'(0));

        // readback R10
        reset_mode = 1'b1; rb_ptr = 4'd9;
        for (int s = 0; s < 3; s++) begin
            rb_sel = 2'(s);
            #1;
            chk(rb_data == tb_cam[9][47 - 16 * s -: 16], "R10 readback word",
                64'(rb_data), 64'(tb_cam[9][47 - 16 * s -: 16]));
        end
        rb_sel = 2'd3; #1;
        chk(rb_data == 16'h0, "R10 select 3 zero", 64'(rb_data), 64'(0));
        rb_sel = 2'd1; reset_mode = 1'b0; #1;
        chk(rb_data == 16'h0, "R10 outside reset mode", 64'(rb_data), 64'(0));

        // filtering, no modes (R4)
        rx_mode = 16'h0000;
        send(48'h0200_1122_3344);
        send(48'h0A0B_0C0D_0E0F);
        send(48'h0200_1122_3345);
        send(48'h0300_5E00_0001);
        send(48'hFFFF_FFFF_FFFF);
        // promiscuous (R1)
        rx_mode = 16'h1000;
        send(48'h0600_0000_0042);
        send(48'h0100_0000_0007);
        send(48'h0300_5E00_0001);
        // all multicast (R2)
        rx_mode = 16'h0800;
        send(48'h0100_0000_0007);
        rx_mode = 16'h2800;
        send(48'hFFFF_FFFF_FFFF);
        // broadcast only (R3)
        rx_mode = 16'h2000;
        send(48'hFFFF_FFFF_FFFF);
        send(48'h0100_0000_0007);

        // wide load, two descriptors (R7)
        put_entry(32'h200, 1'b1, 0, 16'h0005, 48'h0400_0000_0005);
        put_entry(32'h200, 1'b1, 1, 16'h00FC, 48'h0400_0000_000C);
        put_en(32'h200, 1'b1, 2, 16'h1028);
        run_load(32'h200, 1'b1, 16'h0022, 16'h1028, 1'b0);
        rx_mode = 16'h0000;
        send(48'h0400_0000_0005);
        send(48'h0400_0000_000C);
        send(48'h0200_1122_3344);

        // zero low count: enable word only (R6, R8)
        put_en(32'h300, 1'b0, 0, 16'hFFFF);
        run_load(32'h300, 1'b0, 16'h0020, 16'hFFFF, 1'b0);
        send(48'h0A0B_0C0D_0E0F);
        send(48'h0300_5E00_0001);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 every strobe decided", 64'(exp_q.size()), 64'(0));
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule